// File: doc/BRIEF.md
# Non-volatile memory access guard

This block sits on the path from a processor's memory port to a non-volatile storage array. Each request carries a 24-bit byte address, which the block sorts into one of four windows: the data store, the configuration block, the protected start-up area at the base of program space, or the rest of program space. Any address outside these windows is marked unmapped. Reads pass straight through to the array. When the slow-clock option is set, the block adds one cycle to each read so that the core can run faster than the array's native access time allows.

Writes are checked before they reach the array's write strobe. The start-up area grows upward from the program base in 512-byte pages. Its length comes from a page-count input that is never allowed below two pages, and the area refuses every write, whatever the unlock inputs say. The rest of program space, the data store and the configuration block each have their own permission input. A refused write never pulses the array strobe. Instead it raises a one-cycle error flag on the following cycle.

The unlock flags, the page count and the slow-clock option arrive as plain inputs. Key sequences and programming timing are handled elsewhere.

Top module: `nvm_guard`

## Requirements
- R1: The region output, valid while a request is presented, encodes the address as follows: 1 for 0x004000–0x0047FF (data store), 2 for 0x004800–0x00487F (configuration block), 3 for the start-up area, 4 for the rest of 0x008000–0x027FFF, and 0 for any other address.
- R2: The start-up area runs from 0x008000 to 0x008000 + P×512 − 1. P is the page-count input, raised to 2 when it is below 2, and the upper end is clamped to 0x027FFF.
- R3: A write into the start-up area (region 3) never asserts the array write strobe, even with the program unlock input high.
- R4: A write to region 4 asserts the array write strobe only while the program unlock input is high.
- R5: A write to region 1 asserts the array write strobe only while the data unlock input is high.
- R6: A write to region 2 asserts the array write strobe only while the configuration-write enable input is high.
- R7: A write to an unmapped address (region 0) never asserts the array write strobe.
- R8: A refused write raises the error output for exactly one cycle, namely the cycle after the one in which the write completed. An accepted write leaves the error output low in that cycle.
- R9: With the slow-clock option low, a read is ready in its first cycle. With it high, ready is low in the first cycle and high in the second. A write is always ready in its first cycle.
- R10: A read of a mapped address asserts the array read enable and returns the array's data. A read of an unmapped address keeps the read enable low and returns zero.
- R11: After reset the error output is low and no wait cycle is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; held with its fields until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Request completes in this cycle |
| rd_data | output | 8 | Read data returned to the requester |
| region | output | 3 | Decoded window of the current address |
| prot_err | output | 1 | One-cycle pulse after a refused write |
| prog_unlock | input | 1 | Permits writes to program space outside the start-up area |
| data_unlock | input | 1 | Permits writes to the data store |
| cfg_wr_en | input | 1 | Permits writes to the configuration block |
| boot_pages | input | 9 | Start-up area length in 512-byte pages |
| slow_clk | input | 1 | Adds one wait cycle to reads |
| arr_addr | output | 24 | Address to the array |
| arr_wdata | output | 8 | Write data to the array |
| arr_rd_en | output | 1 | Array read enable |
| arr_wr_en | output | 1 | Array write strobe |
| arr_rdata | input | 8 | Data from the array |

## Verification
Error reporting and read stretching can land in the same cycle. This happens when a read with the slow-clock option set directly follows a refused write. The error pulse for the write then appears during the read's inserted wait cycle, while ready is held low. The bench drives the refused write and the stretched read back to back with no idle cycle between them. It then checks, in that single cycle, that the error flag is high and that the read's ready is still low, and one cycle later that the read completes with the array data and the error flag has dropped.

// File: rtl/nvm_guard_pkg.sv
package nvm_guard_pkg;

    typedef enum logic [2:0] {
        RGN_NONE = 3'd0,
        RGN_DATA = 3'd1,
        RGN_CFG  = 3'd2,
        RGN_BOOT = 3'd3,
        RGN_MAIN = 3'd4
    } rgn_e;

    // registered state of the guard
    typedef struct packed {
        logic wait_pend;
        logic err;
    } guard_state_t;

endpackage

// File: rtl/nvm_region_dec.sv
module nvm_region_dec
    import nvm_guard_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int PAGE_W     = 9,
    parameter int DATA_BASE  = 32'h0000_4000,
    parameter int DATA_BYTES = 2048,
    parameter int CFG_BASE   = 32'h0000_4800,
    parameter int CFG_BYTES  = 128,
    parameter int PROG_BASE  = 32'h0000_8000,
    parameter int PROG_LAST  = 32'h0002_7FFF,
    parameter int PAGE_BYTES = 512,
    parameter int MIN_PAGES  = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [PAGE_W-1:0] boot_pages,
    output rgn_e              rgn
);
    localparam int        XW         = ADDR_W + 1;
    localparam int        PAGE_SHIFT = $clog2(PAGE_BYTES);
    localparam logic [XW-1:0] DATA_LO = XW'(DATA_BASE);
    localparam logic [XW-1:0] DATA_HI = XW'(DATA_BASE + DATA_BYTES - 1);
    localparam logic [XW-1:0] CFG_LO  = XW'(CFG_BASE);
    localparam logic [XW-1:0] CFG_HI  = XW'(CFG_BASE + CFG_BYTES - 1);
    localparam logic [XW-1:0] PROG_LO = XW'(PROG_BASE);
    localparam logic [XW-1:0] PROG_HI = XW'(PROG_LAST);
    localparam logic [PAGE_W-1:0] PMIN = PAGE_W'(MIN_PAGES);

    logic [PAGE_W-1:0] pages_eff;
    logic [XW-1:0]     span;
    logic [XW-1:0]     end_raw;
    logic [XW-1:0]     boot_end;
    logic [XW-1:0]     a_x;

    always_comb begin
        pages_eff = (boot_pages < PMIN) ? PMIN : boot_pages;
        span      = XW'(pages_eff) << PAGE_SHIFT;
        end_raw   = PROG_LO + span - XW'(1);
        boot_end  = (end_raw > PROG_HI) ? PROG_HI : end_raw;
        a_x       = {1'b0, addr};

        if (a_x >= DATA_LO && a_x <= DATA_HI) begin
            rgn = RGN_DATA;
        end else if (a_x >= CFG_LO && a_x <= CFG_HI) begin
            rgn = RGN_CFG;
        end else if (a_x >= PROG_LO && a_x <= boot_end) begin
            rgn = RGN_BOOT;
        end else if (a_x > boot_end && a_x <= PROG_HI) begin
            rgn = RGN_MAIN;
        end else begin
            rgn = RGN_NONE;
        end
    end

endmodule

// File: rtl/nvm_write_gate.sv
module nvm_write_gate
    import nvm_guard_pkg::*;
(
    input  rgn_e rgn,
    input  logic prog_unlock,
    input  logic data_unlock,
    input  logic cfg_wr_en,
    output logic wr_ok
);
    always_comb begin
        unique case (rgn)
            RGN_DATA: wr_ok = data_unlock;
            RGN_CFG:  wr_ok = cfg_wr_en;
            RGN_MAIN: wr_ok = prog_unlock;
            RGN_BOOT: wr_ok = 1'b0;
            default:  wr_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/nvm_wait_ctl.sv
module nvm_wait_ctl (
    input  logic req_valid,
    input  logic req_write,
    input  logic slow_clk,
    input  logic pend_q,
    output logic ready,
    output logic pend_d
);
    logic is_rd;

    always_comb begin
        is_rd  = req_valid && !req_write;
        ready  = req_valid && (req_write || !slow_clk || pend_q);
        pend_d = is_rd && slow_clk && !pend_q;
    end

endmodule

// File: rtl/nvm_guard.sv
module nvm_guard
    import nvm_guard_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic [2:0]        region,
    output logic              prot_err,
    input  logic              prog_unlock,
    input  logic              data_unlock,
    input  logic              cfg_wr_en,
    input  logic [PAGE_W-1:0] boot_pages,
    input  logic              slow_clk,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              arr_rd_en,
    output logic              arr_wr_en,
    input  logic [DATA_W-1:0] arr_rdata
);
    guard_state_t st_d, st_q;
    rgn_e         rgn;
    logic         wr_ok;
    logic         mapped;
    logic         pend_nx;

    nvm_region_dec #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_dec (
        .addr       (req_addr),
        .boot_pages (boot_pages),
        .rgn        (rgn)
    );

    nvm_write_gate u_gate (
        .rgn         (rgn),
        .prog_unlock (prog_unlock),
        .data_unlock (data_unlock),
        .cfg_wr_en   (cfg_wr_en),
        .wr_ok       (wr_ok)
    );

    nvm_wait_ctl u_wait (
        .req_valid (req_valid),
        .req_write (req_write),
        .slow_clk  (slow_clk),
        .pend_q    (st_q.wait_pend),
        .ready     (req_ready),
        .pend_d    (pend_nx)
    );

    always_comb begin
        mapped    = (rgn != RGN_NONE);
        arr_addr  = req_addr;
        arr_wdata = req_wdata;
        arr_rd_en = req_valid && !req_write && mapped;
        arr_wr_en = req_valid && req_write && wr_ok;
        rd_data   = arr_rd_en ? arr_rdata : '0;
        region    = rgn;
        prot_err  = st_q.err;

        st_d           = st_q;
        st_d.wait_pend = pend_nx;
        st_d.err       = req_valid && req_write && !wr_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/nvm_guard_chk.sv
module nvm_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_write,
    input logic       req_ready,
    input logic [2:0] region,
    input logic       prot_err,
    input logic       prog_unlock,
    input logic       slow_clk,
    input logic       arr_rd_en,
    input logic       arr_wr_en
);
    AST_BOOT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_en |-> region != 3'd3); // R3

    AST_MAIN_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr_en && region == 3'd4) |-> prog_unlock); // R4

    AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_en |-> region != 3'd0); // R7

    AST_ERR_AFTER_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !arr_wr_en) |=> prot_err); // R8

    AST_NO_ERR_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write && !arr_wr_en) |=> !prot_err); // R8

    AST_FAST_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !slow_clk) |-> req_ready); // R9

    AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |-> req_ready); // R9

    AST_SLOW_READ_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && slow_clk && !req_ready) |=> req_ready); // R9

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_rd_en && arr_wr_en)); // R10

endmodule

bind nvm_guard nvm_guard_chk u_chk (.*);

// File: tb/tb_nvm_guard.sv
module tb_nvm_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, prot_err, arr_rd_en, arr_wr_en;
    logic [7:0]  rd_data, arr_wdata, arr_rdata;
    logic [2:0]  region;
    logic [23:0] arr_addr;
    logic        prog_unlock = 1'b0, data_unlock = 1'b0, cfg_wr_en = 1'b0, slow_clk = 1'b0;
    logic [8:0]  boot_pages = '0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    assign arr_rdata = arr_addr[7:0] ^ 8'h5A;

    nvm_guard dut (.*);

    typedef struct {
        bit         wr;
        bit         exp_we;
        logic [2:0] exp_rgn;
        logic [7:0] exp_rd;
        int         exp_lat;
        bit         exp_err;
        string      tag;
    } exp_t;

    exp_t sbq[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // reference model from the requirements
    function automatic logic [2:0] model_rgn(input logic [23:0] a, input int pages);
        int p;
        int e;
        int ai;
        p  = (pages < 2) ? 2 : pages;
        e  = 32'h8000 + p * 512 - 1;
        if (e > 32'h27FFF) e = 32'h27FFF;
        ai = int'(a);
        if (ai >= 32'h4000 && ai <= 32'h47FF) return 3'd1;
        if (ai >= 32'h4800 && ai <= 32'h487F) return 3'd2;
        if (ai >= 32'h8000 && ai <= e) return 3'd3;
        if (ai > e && ai <= 32'h27FFF) return 3'd4;
        return 3'd0;
    endfunction

    task automatic access(input bit wr, input logic [23:0] a, input logic [7:0] d, input string tag);
        exp_t it;
        logic [2:0] r;
        bit ok;
        r = model_rgn(a, int'(boot_pages));
        ok = (r == 3'd1 && data_unlock) || (r == 3'd2 && cfg_wr_en) || (r == 3'd4 && prog_unlock);
        it.wr      = wr;
        it.exp_rgn = r;
        it.exp_we  = wr && ok;
        it.exp_err = wr && !ok;
        it.exp_rd  = (r == 3'd0) ? 8'h00 : (a[7:0] ^ 8'h5A);
        it.exp_lat = (!wr && slow_clk) ? 1 : 0;
        it.tag     = tag;
        sbq.push_back(it);
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            req_valid = 1'b0; req_write = 1'b0;
        end
    endtask

    // monitor / scoreboard
    bit exp_err_next = 0;
    int stall = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            chk(prot_err == exp_err_next, "R8 prot_err", prot_err, exp_err_next);
            exp_err_next = 0;
            if (req_valid && !req_ready) begin
                stall++;
            end else if (req_valid && req_ready) begin
                if (sbq.size() == 0) begin
                    chk(1'b0, "scoreboard empty", 0, 1);
                end else begin
                    exp_t it;
                    it = sbq.pop_front();
                    chk(region == it.exp_rgn, {"R1 region ", it.tag}, region, it.exp_rgn);
                    chk(arr_wr_en == it.exp_we, {"wr strobe ", it.tag}, arr_wr_en, it.exp_we);
                    chk(stall == it.exp_lat, {"R9 latency ", it.tag}, stall, it.exp_lat);
                    if (!it.wr) begin
                        chk(rd_data == it.exp_rd, {"R10 rd_data ", it.tag}, rd_data, it.exp_rd);
                        chk(arr_rd_en == (it.exp_rgn != 3'd0), {"R10 rd_en ", it.tag},
                            arr_rd_en, (it.exp_rgn != 3'd0));
                    end
                    exp_err_next = it.exp_err;
                end
                stall = 0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(prot_err == 1'b0, "R11 reset prot_err", prot_err, 0);
        chk(req_ready == 1'b0, "R11 reset ready", req_ready, 0);
        rst_n = 1'b1;
        idle(2);

        // R1 R10 reads, no wait
        access(0, 24'h004000, 8'h0, "R1 data lo");
        access(0, 24'h0047FF, 8'h0, "R1 data hi");
        access(0, 24'h004800, 8'h0, "R1 cfg lo");
        access(0, 24'h00487F, 8'h0, "R1 cfg hi");
        access(0, 24'h004880, 8'h0, "R10 unmapped after cfg");
        access(0, 24'h008000, 8'h0, "R1 vectors");
        access(0, 24'h009000, 8'h0, "R1 main");
        access(0, 24'h027FFF, 8'h0, "R1 main top");
        access(0, 24'h028000, 8'h0, "R10 unmapped high");
        access(0, 24'h001000, 8'h0, "R10 unmapped low");

        // locked writes
        access(1, 24'h004010, 8'h11, "R5 data locked");
        access(1, 24'h004810, 8'h22, "R6 cfg locked");
        access(1, 24'h009000, 8'h33, "R4 main locked");
        idle(1);

        prog_unlock = 1; data_unlock = 1; cfg_wr_en = 1;
        idle(1);
        access(1, 24'h004010, 8'h44, "R5 data open");
        chk(arr_wdata == 8'h44, "R5 wdata", arr_wdata, 8'h44);
        access(1, 24'h004810, 8'h55, "R6 cfg open");
        access(1, 24'h008400, 8'h66, "R2 R4 main above min boot");
        access(1, 24'h0083FF, 8'h77, "R2 R3 min boot end");
        access(1, 24'h008000, 8'h88, "R3 vectors unlocked");
        access(1, 24'h003000, 8'h99, "R7 unmapped");
        access(1, 24'h028000, 8'h99, "R7 unmapped high");
        access(1, 24'h009000, 8'hAA, "R4 main open");
        idle(1);

        boot_pages = 9'd4;
        idle(1);
        access(1, 24'h0087FF, 8'h01, "R2 R3 4 pages end");
        access(1, 24'h008800, 8'h02, "R2 R4 4 pages next");
        idle(1);

        boot_pages = 9'd300;
        idle(1);
        access(1, 24'h027FFF, 8'h03, "R2 R3 clamp top");
        access(1, 24'h020000, 8'h04, "R2 R3 clamp mid");
        idle(1);

        boot_pages = 9'd1;
        slow_clk = 1;
        idle(1);
        access(0, 24'h004020, 8'h0, "R9 slow data read");
        access(0, 24'h009100, 8'h0, "R9 slow main read");
        access(1, 24'h004030, 8'h05, "R9 write under slow");
        // refused write then stretched read: error lands in the wait cycle
        access(1, 24'h008010, 8'h06, "R8 refused before read");
        access(0, 24'h004040, 8'h0, "R8 R9 read after refuse");
        access(0, 24'h001234, 8'h0, "R10 slow unmapped");
        idle(1);

        slow_clk = 0; prog_unlock = 0;
        idle(1);
        access(1, 24'h009000, 8'h07, "R8 back-to-back refuse a");
        access(1, 24'h009001, 8'h08, "R8 back-to-back refuse b");
        access(1, 24'h004050, 8'h09, "R8 accept after refuse");
        idle(3);

        chk(sbq.size() == 0, "scoreboard drained", sbq.size(), 0);
        finish_run();
    end

endmodule